// File: doc/BRIEF.md
# Dual-Lane Byte Extend-and-Accumulate Unit

This block takes one source word made of four bytes and rotates it right by a whole number of bytes. From the rotated word it takes the lowest byte and the byte two places above it. Each of the two bytes is widened to a halfword lane, by sign extension or by zero extension. When accumulation is on, each widened lane is added to the matching halfword of a second operand. The two lane sums are computed separately: each wraps within its own halfword, and no carry passes from the low lane into the high lane.

The unit sits in an execution pipeline. It unpacks packed byte data into halfword lanes and can add that data to running per-lane totals in the same operation. A parameter selects whether the result is held in an output register that loads when a valid input arrives, or is passed straight through. Another parameter sets the byte width; the word, lane and rotation widths all follow from it.

Top module: `byteLaneExtAcc`

## Requirements
- R1: The source word is rotated right by 0, 1, 2 or 3 bytes before bytes 0 and 2 are taken. The 2-bit rotate code means 00 = 0, 01 = one byte, 10 = two bytes, 11 = three bytes. Example with 8-bit bytes, signed mode: source 0x80830168 with code 01 gives 0xFF800001, with code 10 gives 0x0068FF83, and with code 11 gives 0x0001FF80.
- R2: When signedMode is 1, each selected byte is sign-extended into its lane. Byte 0 goes to the low lane (result bits [2B-1:0]) and byte 2 goes to the high lane, where B is the byte width. Example: source 0x80830168 with code 00 gives 0xFF830068.
- R3: When signedMode is 0, each selected byte is zero-extended. Example: source 0x80830168 with code 00 gives 0x00830068.
- R4: When accEn is 1, each extended byte is added to the matching halfword of accWord. Example: accWord 0x000D0008 with source 0x80830168, signed, code 00 gives 0xFF900070.
- R5: Each lane sum wraps modulo 2^(2B) and never carries into the other lane. Example: accWord 0xFFF60015, source 0x70880168, signed, code 10 gives 0x005EFF9D.
- R6: When accEn is 0, accWord has no effect on the result. Example: accWord 0x12345678, source 0x80830168, signed, code 00 gives 0xFF830068.
- R7: With REG_OUT = 1, the result loads on the clock edge at which inValid is 1. outValid is 1 in the cycle after an accepted input and 0 otherwise. The result holds its value while inValid is 0.
- R8: While rstN is low, the result is 0 and outValid is 0.
- R9: With REG_OUT = 0, the result is a combinational function of the current inputs, and outValid equals inValid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input operands are valid this cycle |
| srcWord | input | 4*BYTE_W | Source word holding four bytes |
| accWord | input | 4*BYTE_W | Accumulate operand, two halfword lanes |
| rotSel | input | 2 | Rotate-right code, in bytes |
| signedMode | input | 1 | 1 = sign extension, 0 = zero extension |
| accEn | input | 1 | 1 = add lanes to accWord halves |
| result | output | 4*BYTE_W | Two halfword lane results |
| outValid | output | 1 | Result is valid |

## Verification
The bench builds two copies of the unit. The first uses 8-bit bytes and a registered output. It runs the worked examples above and then a long pseudo-random sweep through every rotation, extension and accumulate setting; this covers the pipeline timing, the hold behaviour and the reset state. The second uses 2-bit bytes and a combinational output. With an 8-bit word, every source value can be crossed with every rotation and mode and with accumulate operands chosen to saturate both lanes. This reaches every sign pattern, every wrap of a lane sum and every rotated byte position exhaustively.

// File: rtl/byteLaneExtAcc_pkg.sv
package byteLaneExtAcc_pkg;
  localparam int ROT_SEL_W = 2;
  localparam int NUM_BYTES = 4;
  localparam int NUM_LANES = 2;

  typedef struct packed {
    logic                 capture;
    logic                 signExt;
    logic                 addEn;
    logic [ROT_SEL_W-1:0] rot;
  } ctrlStrobes_t;
endpackage

// File: rtl/byteLaneExtAcc_ctrl.sv
module byteLaneExtAcc_ctrl
  import byteLaneExtAcc_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [ROT_SEL_W-1:0] rotSel,
  input  logic                 signedMode,
  input  logic                 accEn,
  output ctrlStrobes_t         strobes,
  output logic                 outValid
);
  always_comb begin
    strobes.capture = inValid;
    strobes.signExt = signedMode;
    strobes.addEn   = accEn;
    strobes.rot     = rotSel;
  end

  generate
    if (REG_OUT) begin : g_validReg
      logic validQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) validQ <= 1'b0;
        else       validQ <= inValid;
      end
      assign outValid = validQ;
    end else begin : g_validPass
      logic unusedClocking;
      assign unusedClocking = clk ^ rstN;
      assign outValid = inValid;
    end
  endgenerate
endmodule

// File: rtl/byteLaneExtAcc_dp.sv
module byteLaneExtAcc_dp
  import byteLaneExtAcc_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobes_t                  strobes,
  input  logic [NUM_BYTES*BYTE_W-1:0]   srcWord,
  input  logic [NUM_BYTES*BYTE_W-1:0]   accWord,
  output logic [NUM_BYTES*BYTE_W-1:0]   result
);
  localparam int WORD_W   = NUM_BYTES * BYTE_W;
  localparam int LANE_W   = 2 * BYTE_W;
  localparam int NUM_ROTS = 1 << ROT_SEL_W;

  logic [2*WORD_W-1:0] doubled;
  logic [WORD_W-1:0]   rotCand [NUM_ROTS];
  logic [WORD_W-1:0]   rotated;
  logic [WORD_W-1:0]   combResult;

  assign doubled = {srcWord, srcWord};

  // Each candidate is the source rotated right by k bytes.
  generate
    for (genvar k = 0; k < NUM_ROTS; k++) begin : g_rot
      assign rotCand[k] = doubled[k*BYTE_W +: WORD_W];
    end
  endgenerate

  assign rotated = rotCand[strobes.rot];

  // Independent lanes: the carry out of each lane is dropped.
  generate
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      logic [BYTE_W-1:0] pickedByte;
      logic [LANE_W-1:0] widened;
      logic [LANE_W-1:0] addend;
      logic              fillBit;
      assign pickedByte = rotated[l*LANE_W +: BYTE_W];
      assign fillBit    = strobes.signExt & pickedByte[BYTE_W-1];
      assign widened    = {{BYTE_W{fillBit}}, pickedByte};
      assign addend     = strobes.addEn ? accWord[l*LANE_W +: LANE_W] : '0;
      assign combResult[l*LANE_W +: LANE_W] = widened + addend;
    end
  endgenerate

  generate
    if (REG_OUT) begin : g_outReg
      logic [WORD_W-1:0] resultQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                resultQ <= '0;
        else if (strobes.capture) resultQ <= combResult;
      end
      assign result = resultQ;
    end else begin : g_outPass
      logic unusedClocking;
      assign unusedClocking = clk ^ rstN ^ strobes.capture;
      assign result = combResult;
    end
  endgenerate
endmodule

// File: rtl/byteLaneExtAcc.sv
module byteLaneExtAcc
  import byteLaneExtAcc_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        inValid,
  input  logic [NUM_BYTES*BYTE_W-1:0] srcWord,
  input  logic [NUM_BYTES*BYTE_W-1:0] accWord,
  input  logic [ROT_SEL_W-1:0]        rotSel,
  input  logic                        signedMode,
  input  logic                        accEn,
  output logic [NUM_BYTES*BYTE_W-1:0] result,
  output logic                        outValid
);
  ctrlStrobes_t strobes;

  byteLaneExtAcc_ctrl #(.REG_OUT(REG_OUT)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .rotSel     (rotSel),
    .signedMode (signedMode),
    .accEn      (accEn),
    .strobes    (strobes),
    .outValid   (outValid)
  );

  byteLaneExtAcc_dp #(.BYTE_W(BYTE_W), .REG_OUT(REG_OUT)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .srcWord (srcWord),
    .accWord (accWord),
    .result  (result)
  );
endmodule

// File: rtl/byteLaneExtAcc_chk.sv
module byteLaneExtAcc_chk #(
  parameter int BYTE_W  = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              signedMode,
  input logic              accEn,
  input logic [4*BYTE_W-1:0] result,
  input logic              outValid
);
  localparam int LANE_W = 2 * BYTE_W;

  generate
    if (REG_OUT) begin : g_regChecks
      p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> outValid);
      p_valid_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> !outValid);
      p_result_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> $stable(result));
      p_reset_clear_r8: assert property (@(posedge clk)
        !rstN |=> (!outValid && result == '0));
      for (genvar l = 0; l < 2; l++) begin : g_lane
        p_sign_fill_r2: assert property (@(posedge clk) disable iff (!rstN)
          (inValid && signedMode && !accEn) |=>
            result[l*LANE_W+BYTE_W +: BYTE_W] == {BYTE_W{result[l*LANE_W+BYTE_W-1]}});
        p_zero_fill_r3: assert property (@(posedge clk) disable iff (!rstN)
          (inValid && !signedMode && !accEn) |=>
            result[l*LANE_W+BYTE_W +: BYTE_W] == '0);
      end
    end else begin : g_combChecks
      for (genvar l = 0; l < 2; l++) begin : g_lane
        p_sign_fill_r2: assert property (@(posedge clk) disable iff (!rstN)
          (signedMode && !accEn) |->
            result[l*LANE_W+BYTE_W +: BYTE_W] == {BYTE_W{result[l*LANE_W+BYTE_W-1]}});
        p_zero_fill_r3: assert property (@(posedge clk) disable iff (!rstN)
          (!signedMode && !accEn) |->
            result[l*LANE_W+BYTE_W +: BYTE_W] == '0);
      end
      p_valid_pass_r9: assert property (@(posedge clk) disable iff (!rstN)
        inValid |-> outValid);
    end
  endgenerate
endmodule

bind byteLaneExtAcc byteLaneExtAcc_chk #(.BYTE_W(BYTE_W), .REG_OUT(REG_OUT)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .signedMode (signedMode),
  .accEn      (accEn),
  .result     (result),
  .outValid   (outValid)
);

// File: tb/byteLaneExtAcc_tb_top.sv
`timescale 1ns/1ps
module byteLaneExtAcc_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  // Registered copy, 8-bit bytes
  logic        inValid = 0, signedMode = 0, accEn = 0;
  logic [31:0] srcWord = 0, accWord = 0;
  logic [1:0]  rotSel = 0;
  logic [31:0] result;
  logic        outValid;

  // Combinational copy, 2-bit bytes
  logic       sInValid = 0, sSigned = 0, sAccEn = 0;
  logic [7:0] sSrc = 0, sAcc = 0;
  logic [1:0] sRot = 0;
  logic [7:0] sResult;
  logic       sOutValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  byteLaneExtAcc #(.BYTE_W(8), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcWord(srcWord),
    .accWord(accWord), .rotSel(rotSel), .signedMode(signedMode),
    .accEn(accEn), .result(result), .outValid(outValid));

  byteLaneExtAcc #(.BYTE_W(2), .REG_OUT(1'b0)) dutSmall_i (
    .clk(clk), .rstN(rstN), .inValid(sInValid), .srcWord(sSrc),
    .accWord(sAcc), .rotSel(sRot), .signedMode(sSigned),
    .accEn(sAccEn), .result(sResult), .outValid(sOutValid));

  function automatic longint refModel(int bw, longint src, longint acc,
                                      int rot, bit sgn, bit accE);
    longint wordMask, laneMask, byteMask, rotated, res;
    int     w, s;
    w        = 4 * bw;
    s        = rot * bw;
    wordMask = (64'sd1 <<< w) - 1;
    laneMask = (64'sd1 <<< (2 * bw)) - 1;
    byteMask = (64'sd1 <<< bw) - 1;
    rotated  = ((src >>> s) | (src <<< (w - s))) & wordMask;
    res = 0;
    for (int l = 0; l < 2; l++) begin
      longint b, ext, add;
      b   = (rotated >>> (l * 2 * bw)) & byteMask;
      ext = (sgn && ((b >>> (bw - 1)) & 1) == 1) ? b - (byteMask + 1) : b;
      add = accE ? ((acc >>> (l * 2 * bw)) & laneMask) : 0;
      res = res | (((ext + add) & laneMask) <<< (l * 2 * bw));
    end
    return res;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Present one vector to the registered copy and check the cycle after.
  task automatic applyReg(logic [31:0] src, logic [31:0] acc, logic [1:0] rot,
                          bit sgn, bit accE, longint exp, string tag);
    @(negedge clk);
    srcWord = src; accWord = acc; rotSel = rot;
    signedMode = sgn; accEn = accE; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(tag, longint'(result), exp);
    check({tag, " R7 outValid"}, longint'(outValid), 1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsrA, lfsrB;
    repeat (3) @(negedge clk);
    check("R8 result in reset", longint'(result), 0);
    check("R8 outValid in reset", longint'(outValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R7 outValid idle", longint'(outValid), 0);

    applyReg(32'h80830168, 32'h0, 2'b00, 1, 0, 64'hFF830068, "R2 signed rot0");
    applyReg(32'h80830168, 32'h0, 2'b01, 1, 0, 64'hFF800001, "R1 signed rot8");
    applyReg(32'h80830168, 32'h0, 2'b10, 1, 0, 64'h0068FF83, "R1 signed rot16");
    applyReg(32'h80830168, 32'h0, 2'b11, 1, 0, 64'h0001FF80, "R1 signed rot24");
    applyReg(32'h80830168, 32'h0, 2'b00, 0, 0, 64'h00830068, "R3 unsigned rot0");
    applyReg(32'h80830168, 32'h000D0008, 2'b00, 1, 1, 64'hFF900070, "R4 accumulate");
    applyReg(32'h70880168, 32'hFFF60015, 2'b10, 1, 1, 64'h005EFF9D, "R5 lane wrap");
    applyReg(32'h80830168, 32'h12345678, 2'b00, 1, 0, 64'hFF830068, "R6 acc ignored");

    // R7: inputs change without inValid; result must hold, outValid low.
    @(negedge clk);
    srcWord = 32'h7F7F7F7F; accWord = 32'h11111111; accEn = 1; rotSel = 2'b01;
    @(negedge clk);
    check("R7 hold result", longint'(result), 64'hFF830068);
    check("R7 outValid low", longint'(outValid), 0);

    // Pseudo-random sweep on the registered copy.
    lfsrA = 32'hACE1_2468;
    lfsrB = 32'h1357_9BDF;
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] r;
      bit sg, ae;
      string tg;
      lfsrA = {lfsrA[30:0], lfsrA[31] ^ lfsrA[21] ^ lfsrA[1] ^ lfsrA[0]};
      lfsrB = lfsrB * 32'd1664525 + 32'd1013904223;
      r  = 2'(i % 4);
      sg = ((i / 4) % 2) == 1;
      ae = ((i / 8) % 2) == 1;
      tg = ae ? "R4 R5 sweep" : (sg ? "R2 R6 sweep" : "R3 R6 sweep");
      applyReg(lfsrA, lfsrB, r, sg, ae,
               refModel(8, longint'(lfsrA), longint'(lfsrB), int'(r), sg, ae), tg);
    end

    // Exhaustive sweep of the combinational small copy.
    for (int a = 0; a < 4; a++) begin
      for (int m = 0; m < 16; m++) begin
        for (int s = 0; s < 256; s++) begin
          logic [7:0] accV;
          string tg;
          case (a)
            0: accV = 8'h00;
            1: accV = 8'hFF;
            2: accV = 8'h5A;
            default: accV = 8'hA5;
          endcase
          @(negedge clk);
          sSrc = 8'(s); sAcc = accV; sRot = 2'(m % 4);
          sSigned = ((m / 4) % 2) == 1; sAccEn = ((m / 8) % 2) == 1;
          sInValid = (s % 2) == 1;
          #1;
          tg = sAccEn ? "R9 R1 R4 R5 small" : "R9 R1 R2 R3 R6 small";
          check(tg, longint'(sResult),
                refModel(2, longint'(s), longint'(accV), m % 4, sSigned, sAccEn));
          if (s % 64 == 0) check("R9 outValid pass", longint'(sOutValid), longint'(sInValid));
        end
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule